// File: doc/BRIEF.md
# Seconds Time Counter with Alarm

This block keeps a free-running count of seconds. An internal prescaler divides the system clock into a single-cycle seconds tick. Each tick advances a 32-bit count and raises a sticky per-second flag. A second sticky flag, the alarm flag, is raised when the count first becomes equal to a programmable alarm value.

Software reaches the block through a small synchronous register bus with a byte address. The bus exposes the count, the alarm value and a 16-bit control/status word. The control/status word holds both flags, which are cleared by writing a one to them. It also holds an interrupt enable for each flag and a run bit that starts and stops the time base. A single registered, level-sensitive interrupt line is high while any enabled flag is set.

Top module: `seconds_timer`

## Requirements
- R1: After reset the count, the alarm value, the control/status word, the read data and the interrupt output are all zero.
- R2: The control/status word (offset 0x8) uses bit 7 for the per-second flag, bit 6 for the alarm flag, bit 3 for the per-second interrupt enable, bit 2 for the alarm interrupt enable and bit 0 for run. All other bits of the word and bits 31:16 of the read data always read as zero, whatever is written to them.
- R3: Writing 1 to a flag bit clears that flag. Writing 0 to it leaves it unchanged. The enable and run bits take the written value.
- R4: While run is 1, a tick occurs every TICK_DIV clock cycles. The first tick comes on the TICK_DIV-th clock edge after the edge that set run. Each tick adds one to the count and sets the per-second flag on that same edge.
- R5: While run is 0, the prescaler and the count hold their values, and no per-second flag is raised.
- R6: The alarm flag is set one clock edge after the count becomes equal to the alarm value. It is not set again while the two stay equal, even after software clears it.
- R7: When a hardware set and a software write-one-to-clear of the same flag land on the same clock edge, the flag ends up set.
- R8: The interrupt output is the registered value of (per-second flag AND its enable) OR (alarm flag AND its enable). It lags the flags by one clock edge.
- R9: The count is read and written at offset 0x0 and the alarm value at offset 0x4. A software write to the count takes priority over a tick on the same edge. Read data is registered and shows the register selected by the address one edge earlier. Unmapped offsets read as zero.
- R10: The equality that holds at reset, with count and alarm both zero, does not set the alarm flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| irq | output | 1 | Level interrupt, high while an enabled flag is set |

## Verification
The alarm path is swept over a series of alarm values with a small prescale ratio. The bench counts the clock cycles from setting run to the interrupt, and compares the result with the number predicted from the ratio and the register delays. This separates a wrong prescale ratio, an off-by-one in the compare and a missing output register. In each pass the alarm flag is cleared while the count still equals the alarm. That shows whether the flag fires on the transition into equality or on equality itself. A write-one-to-clear is placed on the exact edge of a tick to expose the set/clear priority. Writes of all ones to reserved bits, reads with run low, and reads with one enable masked check the layout, the hold behaviour and the interrupt masking.

// File: rtl/stc_pkg.sv
package stc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int CTRL_W = 16;

    localparam logic [ADDR_W-1:0] OFS_COUNT = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_ALARM = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'h8;

    localparam int BIT_SEC_FLAG = 7;
    localparam int BIT_ALR_FLAG = 6;
    localparam int BIT_SEC_IE   = 3;
    localparam int BIT_ALR_IE   = 2;
    localparam int BIT_RUN      = 0;

    typedef struct packed {
        logic sec_flag;
        logic alr_flag;
        logic sec_ie;
        logic alr_ie;
        logic run;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_COUNT,
        SEL_ALARM,
        SEL_CTRL
    } sel_e;

    function automatic sel_e decode_addr(logic [ADDR_W-1:0] a);
        case (a)
            OFS_COUNT: return SEL_COUNT;
            OFS_ALARM: return SEL_ALARM;
            OFS_CTRL:  return SEL_CTRL;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [CTRL_W-1:0] pack_ctrl(ctrl_t c);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[BIT_SEC_FLAG] = c.sec_flag;
        w[BIT_ALR_FLAG] = c.alr_flag;
        w[BIT_SEC_IE]   = c.sec_ie;
        w[BIT_ALR_IE]   = c.alr_ie;
        w[BIT_RUN]      = c.run;
        return w;
    endfunction

endpackage

// File: rtl/stc_prescaler.sv
module stc_prescaler #(
    parameter int TICK_DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] phase;

    assign tick = run && (phase == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (run) begin
            if (phase == LAST) phase <= '0;
            else               phase <= phase + 1'b1;
        end
    end

    // R5: stopped prescaler keeps its phase
    p_phase_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(phase));

endmodule

// File: rtl/stc_counter.sv
module stc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_count,
    input  logic             wr_alarm,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] alarm,
    output logic             match_rise
);
    logic equal_now;
    logic equal_q;

    assign equal_now  = (count == alarm);
    assign match_rise = equal_now && !equal_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            alarm   <= '0;
            equal_q <= 1'b1;   // R10: equality present at reset is not an event
        end else begin
            if (wr_count)  count <= wdata;
            else if (tick) count <= count + 1'b1;
            if (wr_alarm)  alarm <= wdata;
            equal_q <= equal_now;
        end
    end

    // R4: a tick without a software write advances the count by one
    p_tick_inc_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_count) |=> (count == $past(count) + 1'b1));

    // R5: no tick and no write leaves the count alone
    p_count_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_count) |=> $stable(count));

    // R9: software write wins over a tick
    p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
        wr_count |=> (count == $past(wdata)));

endmodule

// File: rtl/stc_status.sv
module stc_status
    import stc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              match_rise,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             st,
    output logic              irq
);
    ctrl_t st_next;

    always_comb begin
        st_next = st;
        if (wr_ctrl) begin
            st_next.sec_ie = wdata[BIT_SEC_IE];
            st_next.alr_ie = wdata[BIT_ALR_IE];
            st_next.run    = wdata[BIT_RUN];
            if (wdata[BIT_SEC_FLAG]) st_next.sec_flag = 1'b0;
            if (wdata[BIT_ALR_FLAG]) st_next.alr_flag = 1'b0;
        end
        // R7: hardware set overrides a same-cycle clear
        if (tick)       st_next.sec_flag = 1'b1;
        if (match_rise) st_next.alr_flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            irq <= 1'b0;
        end else begin
            st  <= st_next;
            irq <= (st.sec_flag && st.sec_ie) || (st.alr_flag && st.alr_ie);
        end
    end

    // R7: a tick always leaves the per-second flag set
    p_sec_set_r7: assert property (@(posedge clk) disable iff (rst)
        tick |=> st.sec_flag);

    // R6: entering equality raises the alarm flag on the next edge
    p_alarm_set_r6: assert property (@(posedge clk) disable iff (rst)
        match_rise |=> st.alr_flag);

    // R3: flags never clear without a write
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (!wr_ctrl && st.alr_flag) |=> st.alr_flag);

    // R8: interrupt is the masked OR delayed one edge
    p_irq_lag_r8: assert property (@(posedge clk) disable iff (rst)
        ((st.sec_flag && st.sec_ie) || (st.alr_flag && st.alr_ie)) |=> irq);

endmodule

// File: rtl/seconds_timer.sv
module seconds_timer
    import stc_pkg::*;
#(
    parameter int TICK_DIV = 1000,
    parameter int CNT_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    sel_e             sel;
    logic             tick;
    logic             match_rise;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] alarm;
    ctrl_t            st;
    logic [DATA_W-1:0] rd_mux;

    assign sel = decode_addr(bus_addr);

    stc_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (st.run),
        .tick (tick)
    );

    stc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .wr_count   (bus_wr && sel == SEL_COUNT),
        .wr_alarm   (bus_wr && sel == SEL_ALARM),
        .wdata      (bus_wdata[CNT_W-1:0]),
        .count      (count),
        .alarm      (alarm),
        .match_rise (match_rise)
    );

    stc_status u_st (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .match_rise (match_rise),
        .wr_ctrl    (bus_wr && sel == SEL_CTRL),
        .wdata      (bus_wdata[CTRL_W-1:0]),
        .st         (st),
        .irq        (irq)
    );

    always_comb begin
        case (sel)
            SEL_COUNT: rd_mux = DATA_W'(count);
            SEL_ALARM: rd_mux = DATA_W'(alarm);
            SEL_CTRL:  rd_mux = DATA_W'(pack_ctrl(st));
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_mux;
    end

    // R2: upper half of the read data is always zero for the control word
    p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_CTRL) |=> (bus_rdata[DATA_W-1:CTRL_W] == '0));

    // R5: a stopped time base never raises the per-second flag
    p_no_tick_stopped_r5: assert property (@(posedge clk) disable iff (rst)
        (!st.run && !st.sec_flag && !bus_wr) |=> !st.sec_flag);

endmodule

// File: tb/seconds_timer_test.sv
module seconds_timer_test;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    seconds_timer #(.TICK_DIV(DIV), .CNT_W(32)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int n;
        @(negedge clk);
        do_reset();

        // R1 / R10: reset state, no spurious alarm from the zero equality
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rdata", bus_rdata, 32'h0);
        repeat (5) @(negedge clk);
        rd(4'h8, rv); chk("R10 ctrl after reset", rv, 32'h0);
        rd(4'h0, rv); chk("R1 count", rv, 32'h0);
        rd(4'h4, rv); chk("R1 alarm", rv, 32'h0);

        // R5: stopped time base holds
        repeat (40) @(negedge clk);
        rd(4'h0, rv); chk("R5 count held", rv, 32'h0);
        rd(4'h8, rv); chk("R5 no sec flag", rv, 32'h0);

        // R9: register access
        wr(4'h0, 32'h1234_5678);
        wr(4'h4, 32'hCAFE_F00D);
        rd(4'h0, rv); chk("R9 count rw", rv, 32'h1234_5678);
        rd(4'h4, rv); chk("R9 alarm rw", rv, 32'hCAFE_F00D);
        rd(4'hC, rv); chk("R9 unmapped", rv, 32'h0);

        // R4 / R8: per-second interrupt latency
        do_reset();
        wr(4'h4, 32'hFFFF_0000);
        wr(4'h8, 32'h0000_0009);
        wait_irq(n);
        chk("R4 first tick irq cycles", n, DIV + 1);
        wr(4'h8, 32'h0000_0000);
        rd(4'h0, rv); chk("R4 count one", rv, 32'h1);

        // R7: clear on the tick edge loses to the set
        do_reset();
        wr(4'h8, 32'h0000_0001);
        repeat (DIV - 1) @(negedge clk);
        wr(4'h8, 32'h0000_0081);
        rd(4'h8, rv); chk("R7 set beats clear", rv, 32'h0000_0081);
        wr(4'h8, 32'h0000_0080);

        // R6 / R3 / R8 / R4: alarm sweep
        for (int k = 1; k <= 8; k++) begin
            do_reset();
            wr(4'h0, 32'h0);
            wr(4'h4, k);
            wr(4'h8, 32'h0000_0005);
            wait_irq(n);
            chk("R6 alarm irq cycles", n, k * DIV + 2);
            wr(4'h8, 32'h0000_0004);
            rd(4'h0, rv); chk("R4 count at alarm", rv, k);
            rd(4'h8, rv); chk("R3 flags before clear", rv, 32'h0000_00C4);
            wr(4'h8, 32'h0000_0044);
            rd(4'h8, rv); chk("R6 no reassert while equal", rv, 32'h0000_0084);
            chk("R8 sec masked irq low", {31'b0, irq}, 32'h0);
            repeat (20) @(negedge clk);
            rd(4'h0, rv); chk("R5 count held after stop", rv, k);
        end

        // R2: reserved bits read zero, one-clears flags, zero leaves enables off
        wr(4'h8, 32'hFFFF_FFF2);
        rd(4'h8, rv); chk("R2 reserved zero", rv, 32'h0);
        wr(4'h8, 32'h0000_000D);
        rd(4'h8, rv); chk("R2 enable layout", rv, 32'h0000_000D);
        wr(4'h8, 32'h0000_0000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule